// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words. Words go in on one clock and come out on another. The two clocks may be unrelated, or they may be the same net. A word is stored when the first write enable is low and the second is high. The second write enable also acts as a strobe: while it is held low, each write cycle loads a flag offset from the data input instead of storing a word. That load slot is how software moves the two programmable thresholds away from their reset value of 7 words.

A word is read when both read enables are low. The word appears in a registered output. An active-low output enable decides whether that register drives the data pins or leaves them at high impedance.

Each pointer crosses into the other clock domain as Gray code through two flip-flops.

- The write side works out Full, Half Full and the active-low almost-full flag. These use its own pointer and the synchronized read pointer.
- The read side works out Empty and the active-low almost-empty flag in the same way.

Because of this, each flag can lag the far side by a few cycles, but it never reports a state that is less safe than the true one. Writes into a full buffer and reads from an empty one are dropped.

The depth must be a power of two and at most 512, so that an offset fits in one data word. The offsets are treated as static while traffic flows across the clock boundary.

Top module: `dual_clock_fifo`

## Requirements
- R1: On a write-clock rising edge with wen1_n = 0 and wen2_ld = 1 and Full low, the word on din is stored. A word is stored on every such edge for as long as the enables stay in that state.
- R2: On a read-clock rising edge with ren1_n = 0, ren2_n = 0 and Empty low, the oldest stored word is moved into the output register. Words leave in the order they were written.
- R3: While oe_n = 1, every bit of dout is high impedance. While oe_n = 0, dout shows the output register.
- R4: Once the other side has settled:
  - empty = 1 exactly when no words are held.
  - full = 1 exactly when DEPTH words are held.
  - A write while full = 1 is ignored: no word is stored and none is overwritten.
  - A read while empty = 1 is ignored: dout keeps its value.
- R5: half = 1 exactly when more than DEPTH/2 words are held.
- R6: pae_n = 0 exactly when the number of held words is at most the almost-empty offset. This flag is computed in the read domain.
- R7: paf_n = 0 exactly when the number of free locations is at most the almost-full offset. This flag is computed in the write domain.
- R8: A low rst_n, sampled on both clocks, has these effects:
  - It empties the buffer and clears the output register.
  - It sets empty = 1, pae_n = 0, full = 0, half = 0 and paf_n = 1.
  - It sets both offsets to 7.
- R9: A write-clock edge with wen1_n = 0 and wen2_ld = 0 loads din into an offset register instead of storing a word. The first such load after reset sets the almost-empty offset and the next sets the almost-full offset, after which the two alternate.
- R10: With rclk and wclk tied together, R1 to R7 still hold.
- R11: Whenever no words are held, empty = 1. Whenever DEPTH words are held, full = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock (may be tied to wclk) |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | High: write enable; low: offset load strobe |
| din | input | 9 | Write data or offset value |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low; high gives high impedance |
| dout | output | 9 | Read data |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| half | output | 1 | More than DEPTH/2 words held |
| pae_n | output | 1 | Almost empty, active low |
| paf_n | output | 1 | Almost full, active low |

## Verification
The bench steps the word count across each flag threshold, one word at a time, using both the default offsets and loaded ones. A design that compared with < instead of <= would move pae_n or paf_n one word off. A design that mixed up the order of the two offset loads would swap the two thresholds.

The bench pushes three extra words into a full buffer and then drains it. A design that wrapped its pointer there would return an extra or overwritten word. The bench also reads from an empty buffer. A design that let that read through would change dout.

Concurrent streams run with unrelated clocks and with tied clocks. A design whose synchronized flags lagged in the unsafe direction would show the true empty or full state without the matching flag.

// File: rtl/dcf_pkg.sv
// Package: shared constants and types for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dcf_pkg;

    // Offset value restored by reset for both programmable flags.
    localparam int OFFSET_DEFAULT = 7;

    // Which offset register the next load cycle writes.
    typedef enum logic {
        LOAD_AE = 1'b0,
        LOAD_AF = 1'b1
    } load_sel_t;

endpackage

// File: rtl/dcf_gray_sync.sv
// Module: two-stage synchronizer for a Gray-coded pointer.
// Assumes: the input changes by at most one bit per source clock, so
// each captured value is a valid pointer, either old or new.
module dcf_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Capture into the first stage, then settle into the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/dcf_wr_side.sv
// Module: write-domain control.
// It holds the write pointer and the two offset registers. It derives
// Full, Half Full and the almost-full flag from its own pointer and the
// synchronized read pointer.
// Assumes: DEPTH is a power of two; offsets change only while idle.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 9,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [DW-1:0] din,
    input  logic [PW-1:0] rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [DW-1:0] ae_offset,
    output logic          full,
    output logic          half,
    output logic          paf_n
);

    localparam int CW = (PW > DW) ? PW : DW;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_next;
    logic [PW-1:0] rbin_sync;
    logic [PW-1:0] used;
    logic [PW-1:0] free_cnt;
    logic [DW-1:0] af_offset;
    load_sel_t     load_sel;
    logic          load_cyc;

    // Convert the synchronized read pointer from Gray to binary.
    always_comb begin
        rbin_sync[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin_sync[i] = rbin_sync[i+1] ^ rgray_sync[i];
        end
    end

    // Occupancy and free space as seen from the write side.
    always_comb begin
        used     = wbin - rbin_sync;
        free_cnt = PW'(DEPTH) - used;
        full     = (used == PW'(DEPTH));
        half     = (used > PW'(DEPTH / 2));
        paf_n    = !(CW'(free_cnt) <= CW'(af_offset));
    end

    // Decode write versus offset-load cycles.
    always_comb begin
        mem_we    = !wen1_n && wen2_ld && !full;
        load_cyc  = !wen1_n && !wen2_ld;
        wbin_next = wbin + PW'(1);
        waddr     = wbin[AW-1:0];
    end

    // Advance the write pointer and keep its Gray image registered.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wbin  <= wbin_next;
            wgray <= wbin_next ^ (wbin_next >> 1);
        end
    end

    // Load the offsets in turn, almost-empty first.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_offset <= DW'(OFFSET_DEFAULT);
            af_offset <= DW'(OFFSET_DEFAULT);
            load_sel  <= LOAD_AE;
        end else if (load_cyc) begin
            if (load_sel == LOAD_AE) begin
                ae_offset <= din;
                load_sel  <= LOAD_AF;
            end else begin
                af_offset <= din;
                load_sel  <= LOAD_AE;
            end
        end
    end

endmodule

// File: rtl/dcf_rd_side.sv
// Module: read-domain control.
// It holds the read pointer and derives Empty and the almost-empty flag
// from it and the synchronized write pointer.
// Assumes: ae_offset is static while this domain uses it.
module dcf_rd_side #(
    parameter int DEPTH = 16,
    parameter int DW    = 9,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [PW-1:0] wgray_sync,
    input  logic [DW-1:0] ae_offset,
    output logic          rd_en,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          pae_n
);

    localparam int CW = (PW > DW) ? PW : DW;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_next;
    logic [PW-1:0] wbin_sync;
    logic [PW-1:0] used;

    // Convert the synchronized write pointer from Gray to binary.
    always_comb begin
        wbin_sync[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_sync[i] = wbin_sync[i+1] ^ wgray_sync[i];
        end
    end

    // Occupancy and read qualification as seen from the read side.
    always_comb begin
        used      = wbin_sync - rbin;
        empty     = (used == '0);
        pae_n     = !(CW'(used) <= CW'(ae_offset));
        rd_en     = !ren1_n && !ren2_n && !empty;
        rbin_next = rbin + PW'(1);
        raddr     = rbin[AW-1:0];
    end

    // Advance the read pointer and keep its Gray image registered.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en) begin
            rbin  <= rbin_next;
            rgray <= rbin_next ^ (rbin_next >> 1);
        end
    end

endmodule

// File: rtl/dual_clock_fifo.sv
// Module: top of the dual-clock FIFO.
// It ties the write and read controls, the pointer synchronizers, the
// storage array and the three-state output register together.
// Assumes: DEPTH is a power of two with DEPTH <= 2**DW; rst_n is held
// low for several edges of both clocks.
module dual_clock_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 9
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [DW-1:0] din,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic          half,
    output logic          pae_n,
    output logic          paf_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] waddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_sync;
    logic [DW-1:0] ae_offset;
    logic          rd_en;
    logic [AW-1:0] raddr;
    logic [PW-1:0] rgray;
    logic [PW-1:0] rgray_sync;
    logic [DW-1:0] dout_q;
    logic [DW-1:0] mem [DEPTH];

    dcf_wr_side #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .wen1_n    (wen1_n),
        .wen2_ld   (wen2_ld),
        .din       (din),
        .rgray_sync(rgray_sync),
        .mem_we    (mem_we),
        .waddr     (waddr),
        .wgray     (wgray),
        .ae_offset (ae_offset),
        .full      (full),
        .half      (half),
        .paf_n     (paf_n)
    );

    dcf_rd_side #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .ren1_n    (ren1_n),
        .ren2_n    (ren2_n),
        .wgray_sync(wgray_sync),
        .ae_offset (ae_offset),
        .rd_en     (rd_en),
        .raddr     (raddr),
        .rgray     (rgray),
        .empty     (empty),
        .pae_n     (pae_n)
    );

    dcf_gray_sync #(.W(PW)) u_w2r (
        .clk  (rclk),
        .rst_n(rst_n),
        .d    (wgray),
        .q    (wgray_sync)
    );

    dcf_gray_sync #(.W(PW)) u_r2w (
        .clk  (wclk),
        .rst_n(rst_n),
        .d    (rgray),
        .q    (rgray_sync)
    );

    // Store an accepted word in the array.
    always_ff @(posedge wclk) begin
        if (mem_we) begin
            mem[waddr] <= din;
        end
    end

    // Move the oldest word into the output register on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (rd_en) begin
            dout_q <= mem[raddr];
        end
    end

    // Drive the data pins, or float them while output is disabled.
    assign dout = oe_n ? {DW{1'bz}} : dout_q;

endmodule

// File: rtl/dcf_checker.sv
// Module: assertion checker for dual_clock_fifo, attached by bind.
// Assumes: it is connected to the top's ports and its internal write
// pointer and output register.
module dcf_checker #(
    parameter int PW = 5,
    parameter int DW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen1_n,
    input logic          wen2_ld,
    input logic          ren1_n,
    input logic          ren2_n,
    input logic          empty,
    input logic          full,
    input logic          half,
    input logic          pae_n,
    input logic          paf_n,
    input logic [PW-1:0] wgray,
    input logic [DW-1:0] dout_q
);

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wen1_n && wen2_ld && full) |=> $stable(wgray)); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (!ren1_n && !ren2_n && empty) |=> $stable(dout_q)); // R4

    AST_LOAD_NO_STORE: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wen1_n && !wen2_ld) |=> $stable(wgray)); // R9

    AST_GRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R11

    AST_FULL_IMPLIES_HALF: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> half); // R5

    AST_RESET_WR_FLAGS: assert property (@(posedge wclk)
        !rst_n |=> (!full && !half && paf_n)); // R8

    AST_RESET_RD_FLAGS: assert property (@(posedge rclk)
        !rst_n |=> (empty && !pae_n)); // R8

endmodule

bind dual_clock_fifo dcf_checker #(.PW(PW), .DW(DW)) u_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .rst_n  (rst_n),
    .wen1_n (wen1_n),
    .wen2_ld(wen2_ld),
    .ren1_n (ren1_n),
    .ren2_n (ren2_n),
    .empty  (empty),
    .full   (full),
    .half   (half),
    .pae_n  (pae_n),
    .paf_n  (paf_n),
    .wgray  (wgray),
    .dout_q (dout_q)
);

// File: tb/dual_clock_fifo_test.sv
// Bench: behavioural queue model of the FIFO, compared on every clock
// for the conservative flag rule and on every read for the data. Flags
// are compared in full once both domains have settled.
module dual_clock_fifo_test;

    localparam int WCLK_P = 10;
    localparam int RCLK_P = 14;
    localparam int DEPTH  = 16;
    localparam int DW     = 9;

    logic          wclk = 1'b0;
    logic          rclk_free = 1'b0;
    logic          tie = 1'b0;
    logic          rclk;
    logic          rst_n = 1'b0;
    logic          wen1_n = 1'b1;
    logic          wen2_ld = 1'b1;
    logic [DW-1:0] din = '0;
    logic          ren1_n = 1'b1;
    logic          ren2_n = 1'b1;
    logic          oe_n = 1'b0;
    wire  [DW-1:0] dout;
    logic          empty, full, half, pae_n, paf_n;

    int            checks = 0;
    int            errors = 0;
    int            m_ae = 7;
    int            m_af = 7;
    int            exp_q = 0;
    logic          mon_en = 1'b0;
    logic [DW-1:0] q[$];

    always #(WCLK_P / 2) wclk = ~wclk;
    always #(RCLK_P / 2) rclk_free = ~rclk_free;
    assign rclk = tie ? wclk : rclk_free;

    dual_clock_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n),
        .wen2_ld(wen2_ld), .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .oe_n(oe_n), .dout(dout), .empty(empty), .full(full),
        .half(half), .pae_n(pae_n), .paf_n(paf_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Conservative flag rule, watched on every write and read clock.
    always @(negedge wclk) begin
        if (mon_en && q.size() == DEPTH) check(full == 1'b1, "R11 full at true full", int'(full), 1);
    end
    always @(negedge rclk) begin
        if (mon_en && q.size() == 0) check(empty == 1'b1, "R11 empty at true empty", int'(empty), 1);
    end

    task automatic do_reset();
        mon_en = 1'b0;
        rst_n  = 1'b0;
        wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        q.delete();
        m_ae = 7; m_af = 7; exp_q = 0;
        mon_en = 1'b1;
    endtask

    task automatic wr_burst(input int n, input int base);
        bit f_seen;
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen1_n = 1'b0; wen2_ld = 1'b1; din = DW'(base + i);
            f_seen = full;
            @(posedge wclk);
            if (!f_seen) q.push_back(DW'(base + i));
        end
        @(negedge wclk);
        wen1_n = 1'b1;
    endtask

    task automatic rd_burst(input int n, input string tag);
        bit e_seen;
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            ren1_n = 1'b0; ren2_n = 1'b0;
            e_seen = empty;
            @(posedge rclk);
            if (!e_seen) begin
                if (q.size() == 0) check(1'b0, {tag, " read with nothing held"}, 1, 0);
                else exp_q = int'(q.pop_front());
            end
            #2;
            check(dout === DW'(exp_q), {tag, " read data"}, int'(dout), exp_q);
        end
        @(negedge rclk);
        ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic load_offsets(input int ae, input int af);
        @(negedge wclk); wen1_n = 1'b0; wen2_ld = 1'b0; din = DW'(ae);
        @(posedge wclk);
        @(negedge wclk); din = DW'(af);
        @(posedge wclk);
        @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
        m_ae = ae; m_af = af;
    endtask

    task automatic settle_check(input string ctx);
        int n;
        repeat (6) @(posedge wclk);
        repeat (6) @(posedge rclk);
        @(negedge wclk);
        n = q.size();
        check(empty == (n == 0), $sformatf("%s R4 empty n=%0d", ctx, n), int'(empty), int'(n == 0));
        check(full == (n == DEPTH), $sformatf("%s R4 full n=%0d", ctx, n), int'(full), int'(n == DEPTH));
        check(half == (n > DEPTH / 2), $sformatf("%s R5 half n=%0d", ctx, n), int'(half), int'(n > DEPTH / 2));
        check(pae_n == !(n <= m_ae), $sformatf("%s R6 pae_n n=%0d", ctx, n), int'(pae_n), int'(!(n <= m_ae)));
        check(paf_n == !((DEPTH - n) <= m_af), $sformatf("%s R7 paf_n n=%0d", ctx, n), int'(paf_n), int'(!((DEPTH - n) <= m_af)));
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while (q.size() > 0 && guard < 400) begin
            rd_burst(1, tag);
            guard++;
        end
    endtask

    task automatic stream(input string tag, input int base);
        fork
            wr_burst(40, base);
            rd_burst(45, tag);
        join
        drain(tag);
        settle_check(tag);
    endtask

    initial begin
        #(WCLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        settle_check("R8 after reset");
        #1 check(dout === '0, "R8 output register cleared", int'(dout), 0);
        oe_n = 1'b1;
        #1 check(dout === {DW{1'bz}}, "R3 high impedance", int'(dout === {DW{1'bz}}), 1);
        oe_n = 1'b0;
        #1 check(dout === '0, "R3 driven again", int'(dout), 0);

        // Default thresholds and half mark, one word at a time (R1).
        wr_burst(7, 9'h040);  settle_check("R1 R6 at 7");
        wr_burst(1, 9'h047);  settle_check("R6 at 8");
        wr_burst(1, 9'h048);  settle_check("R5 at 9");
        rd_burst(9, "R2 ordered drain");
        settle_check("R2 drained");
        rd_burst(2, "R4 read while empty ignored");

        // Fill past full; extra words must be dropped.
        wr_burst(8, 9'h100);  settle_check("R7 at 8");
        wr_burst(1, 9'h108);  settle_check("R7 at 9");
        wr_burst(7, 9'h109);  settle_check("R4 full");
        wr_burst(3, 9'h1f0);  settle_check("R4 writes at full ignored");
        rd_burst(DEPTH, "R4 no overwrite");
        settle_check("R4 empty after drain");
        rd_burst(1, "R4 read after drain ignored");

        // Loaded offsets: almost-empty 3, almost-full 2 (R9).
        load_offsets(3, 2);   settle_check("R9 load stores no word");
        wr_burst(3, 9'h020);  settle_check("R9 R6 at 3");
        wr_burst(1, 9'h023);  settle_check("R9 R6 at 4");
        wr_burst(9, 9'h024);  settle_check("R9 R7 at 13");
        wr_burst(1, 9'h02d);  settle_check("R9 R7 at 14");
        drain("R9 drain");

        // Reset must bring the offsets back to 7.
        do_reset();
        wr_burst(7, 9'h0a0);  settle_check("R8 default back at 7");
        wr_burst(1, 9'h0a7);  settle_check("R8 default back at 8");
        drain("R8 drain");

        stream("R1 R2 async stream", 9'h150);

        // Tied clocks.
        rst_n = 1'b0; mon_en = 1'b0;
        repeat (3) @(posedge wclk);
        tie = 1'b1;
        do_reset();
        settle_check("R10 reset tied");
        stream("R10 tied stream", 9'h0c0);
        wr_burst(DEPTH + 2, 9'h0e0);
        settle_check("R10 full tied");
        drain("R10 drain tied");
        settle_check("R10 empty tied");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule